// File: doc/BRIEF.md
# Pointer-Indirect Data Memory Access Unit

This unit carries out single data-memory transfers for a small 8-bit processor core. A transfer names its operand in one of three ways: a direct address supplied with the request, the byte pointed to by the B pointer, or the byte pointed to by the X pointer. Three transfers are supported. A load copies the operand byte into the accumulator. An exchange swaps the accumulator with the operand byte. A store-immediate writes an immediate byte to the operand location. Indirect transfers can leave their pointer alone, or step it up or down by one once the access is done.

The pointers B, X and SP live inside the unit and are mapped into the top of the 8-bit address space: B answers at 0xFE, X at 0xFC and SP at 0xFD. Any access to those three addresses, direct or indirect, reads or writes the live pointer, and the external RAM is not written. A store-immediate with a direct address in the window therefore loads a register with an immediate. Every other address, including the rest of the 0xF0 to 0xFF window, goes to the external RAM. The RAM is read combinationally: `ram_rdata_i` must show the byte at `ram_addr_o` in the same cycle.

The control is a three-state machine. IDLE waits for `start_i`, latches the request and moves to ACCESS. ACCESS drives the operand address. For a load or a store it finishes and returns to IDLE. For an exchange it captures the old byte and moves to SWAP. SWAP writes the latched accumulator to the same address and returns to IDLE. The cycle after the final phase shows `done_o` high, with the new accumulator on `acc_o` and the updated pointers on `b_o`, `x_o` and `sp_o`.

Top module: `ptr_mem_unit`

## Requirements
- R1: After reset `b_o`, `x_o`, `sp_o` and `acc_o` are 0, and `busy_o`, `done_o` and `ram_we_o` are low.
- R2: In the cycle after `start_i` is accepted, `ram_addr_o` is the operand address. Mode code 1 selects B and code 2 selects X. Codes 0 and 3 select `dir_addr_i`.
- R3: A load (op code 0, and op code 3 behaves the same) never writes. One cycle after ACCESS, `done_o` pulses and `acc_o` holds the operand byte.
- R4: An indirect transfer with adjust code 1 adds one to its pointer when it finishes, and adjust code 2 subtracts one. Adjust code 0 or 3 leaves it unchanged. In direct mode the adjust code is ignored. Pointers change at no other time.
- R5: An exchange (op code 1) does not write in ACCESS. In SWAP it writes the latched accumulator to the same address, and `acc_o` then holds the old byte.
- R6: A store-immediate (op code 2) writes `imm_i` to the operand in direct or B mode. In X mode it writes nothing and changes no pointer, but `done_o` still pulses. For a store, `acc_o` takes `acc_i`.
- R7: The addresses 0xFE (B), 0xFC (X) and 0xFD (SP) read and write the live pointer registers, and `ram_we_o` stays low for them.
- R8: When a transfer writes the address of the same pointer it post-adjusts, the written value wins.
- R9: `start_i` is ignored while `busy_o` is high.
- R10: Pointer post-adjust wraps modulo 256: 0xFF up gives 0x00, and 0x00 down gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken in IDLE |
| op_i | input | 2 | 0 load, 1 exchange, 2 store-immediate, 3 load |
| mode_i | input | 2 | 0 direct, 1 via B, 2 via X, 3 direct |
| adj_i | input | 2 | 0 none, 1 increment, 2 decrement, 3 none |
| dir_addr_i | input | 8 | Direct operand address |
| imm_i | input | 8 | Immediate byte for store |
| acc_i | input | 8 | Current accumulator |
| ram_rdata_i | input | 8 | RAM read data for `ram_addr_o` |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| acc_o | output | 8 | New accumulator value |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transfer in progress |
| b_o | output | 8 | B pointer |
| x_o | output | 8 | X pointer |
| sp_o | output | 8 | SP register |

## Verification
Two functions can land on the same register in the same cycle: a pointer post-adjust, and a data write that targets that pointer's own window address. The bench provokes this by first loading B with 0xFE through a direct store. It then runs a B-indirect store with increment, and a B-indirect exchange with decrement. Each result is judged by checking that `b_o` holds the written byte rather than the stepped value. Random transfers mix direct accesses to the window with indirect ones, so a pointer can also be written while the other pointer steps, and a bench model predicts both outcomes.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_SWAP   = 2'd2
    } state_e;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_XCHG  = 2'd1;
    localparam logic [1:0] OP_STORE = 2'd2;

    localparam logic [1:0] MD_DIRECT = 2'd0;
    localparam logic [1:0] MD_BIND   = 2'd1;
    localparam logic [1:0] MD_XIND   = 2'd2;

    localparam logic [1:0] AJ_NONE = 2'd0;
    localparam logic [1:0] AJ_INC  = 2'd1;
    localparam logic [1:0] AJ_DEC  = 2'd2;

endpackage

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import ptr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] dir_addr_i,
    input  logic [W-1:0] b_val_i,
    input  logic [W-1:0] x_val_i,
    output logic [W-1:0] ea_o
);

    always_comb begin
        unique case (mode_i)
            MD_BIND: ea_o = b_val_i;
            MD_XIND: ea_o = x_val_i;
            default: ea_o = dir_addr_i;
        endcase
    end

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
    parameter int           W       = 8,
    parameter logic [W-1:0] B_ADDR  = 8'hFE,
    parameter logic [W-1:0] X_ADDR  = 8'hFC,
    parameter logic [W-1:0] SP_ADDR = 8'hFD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rd_addr_i,
    output logic         rd_hit_o,
    output logic [W-1:0] rd_val_o,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         adj_b_i,
    input  logic         adj_x_i,
    input  logic         adj_down_i,
    output logic [W-1:0] b_o,
    output logic [W-1:0] x_o,
    output logic [W-1:0] sp_o
);

    localparam int NPTR = 3;
    localparam logic [NPTR*W-1:0] SLOT_ADDRS = {SP_ADDR, X_ADDR, B_ADDR};

    logic [W-1:0]    slot_q [NPTR];
    logic [NPTR-1:0] slot_adj;

    assign slot_adj = {1'b0, adj_x_i, adj_b_i};

    for (genvar i = 0; i < NPTR; i++) begin : g_slot
        localparam logic [W-1:0] MY_ADDR = SLOT_ADDRS[i*W +: W];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (wr_en_i && wr_addr_i == MY_ADDR) begin
                slot_q[i] <= wr_data_i;
            end else if (slot_adj[i]) begin
                slot_q[i] <= adj_down_i ? slot_q[i] - 1'b1 : slot_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        rd_hit_o = 1'b0;
        rd_val_o = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (rd_addr_i == SLOT_ADDRS[i*W +: W]) begin
                rd_hit_o = 1'b1;
                rd_val_o = slot_q[i];
            end
        end
    end

    assign b_o  = slot_q[0];
    assign x_o  = slot_q[1];
    assign sp_o = slot_q[2];

endmodule

// File: rtl/ptr_mem_unit.sv
module ptr_mem_unit
    import ptr_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] B_ADDR  = 8'hFE,
    parameter logic [W-1:0] X_ADDR  = 8'hFC,
    parameter logic [W-1:0] SP_ADDR = 8'hFD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [1:0]   mode_i,
    input  logic [1:0]   adj_i,
    input  logic [W-1:0] dir_addr_i,
    input  logic [W-1:0] imm_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] ram_rdata_i,
    output logic [W-1:0] ram_addr_o,
    output logic [W-1:0] ram_wdata_o,
    output logic         ram_we_o,
    output logic [W-1:0] acc_o,
    output logic         done_o,
    output logic         busy_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] x_o,
    output logic [W-1:0] sp_o
);

    state_e state_q, state_d;

    logic [1:0]   op_q, mode_q, adj_q;
    logic [W-1:0] imm_q, acc_q, ea_q, cap_q;
    logic [W-1:0] ea_d;

    logic         ph_read, ph_write;
    logic         store_skip, finish, wr_now, adj_on;
    logic [W-1:0] wr_data, rd_byte;
    logic         win_hit;
    logic [W-1:0] win_val;
    logic         rf_we, adj_b, adj_x;

    ptr_addr_gen #(.W(W)) u_addr (
        .mode_i     (mode_i),
        .dir_addr_i (dir_addr_i),
        .b_val_i    (b_o),
        .x_val_i    (x_o),
        .ea_o       (ea_d)
    );

    ptr_regfile #(
        .W       (W),
        .B_ADDR  (B_ADDR),
        .X_ADDR  (X_ADDR),
        .SP_ADDR (SP_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr_i  (ea_q),
        .rd_hit_o   (win_hit),
        .rd_val_o   (win_val),
        .wr_en_i    (rf_we),
        .wr_addr_i  (ea_q),
        .wr_data_i  (wr_data),
        .adj_b_i    (adj_b),
        .adj_x_i    (adj_x),
        .adj_down_i (adj_q == AJ_DEC),
        .b_o        (b_o),
        .x_o        (x_o),
        .sp_o       (sp_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ACCESS;
            ST_ACCESS: state_d = (op_q == OP_XCHG) ? ST_SWAP : ST_IDLE;
            ST_SWAP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign ph_read  = (state_q == ST_ACCESS);
    assign ph_write = (state_q == ST_SWAP);

    // Outputs and phase controls
    always_comb begin
        store_skip  = (op_q == OP_STORE) && (mode_q == MD_XIND);
        finish      = (ph_read && op_q != OP_XCHG) || ph_write;
        wr_now      = (ph_read && op_q == OP_STORE && !store_skip) || ph_write;
        wr_data     = ph_write ? acc_q : imm_q;
        rd_byte     = win_hit ? win_val : ram_rdata_i;
        adj_on      = finish && !store_skip && (adj_q == AJ_INC || adj_q == AJ_DEC);
        adj_b       = adj_on && (mode_q == MD_BIND);
        adj_x       = adj_on && (mode_q == MD_XIND);
        rf_we       = wr_now && win_hit;
        ram_we_o    = wr_now && !win_hit;
        ram_wdata_o = wr_data;
        ram_addr_o  = ea_q;
        busy_o      = (state_q != ST_IDLE);
    end

    // Request latch and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_LOAD;
            mode_q <= MD_DIRECT;
            adj_q  <= AJ_NONE;
            imm_q  <= '0;
            acc_q  <= '0;
            ea_q   <= '0;
            cap_q  <= '0;
            acc_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= finish;
            if (state_q == ST_IDLE && start_i) begin
                op_q   <= op_i;
                mode_q <= mode_i;
                adj_q  <= adj_i;
                imm_q  <= imm_i;
                acc_q  <= acc_i;
                ea_q   <= ea_d;
            end
            if (ph_read) cap_q <= rd_byte;
            if (finish) begin
                if (ph_write)               acc_o <= cap_q;
                else if (op_q == OP_STORE)  acc_o <= acc_q;
                else                        acc_o <= rd_byte;
            end
        end
    end

endmodule

// File: rtl/ptr_mem_unit_chk.sv
module ptr_mem_unit_chk #(
    parameter int           W       = 8,
    parameter logic [W-1:0] B_ADDR  = 8'hFE,
    parameter logic [W-1:0] X_ADDR  = 8'hFC,
    parameter logic [W-1:0] SP_ADDR = 8'hFD
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy_o,
    input logic         done_o,
    input logic         ram_we_o,
    input logic [W-1:0] ram_addr_o,
    input logic [W-1:0] b_o,
    input logic [W-1:0] x_o,
    input logic [W-1:0] sp_o,
    input logic         ph_read,
    input logic         ph_write
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (b_o == '0 && x_o == '0 && sp_o == '0 && !busy_o && !done_o));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_ptr_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o) |-> ($stable(b_o) && $stable(x_o) && $stable(sp_o)));

    p_swap_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ph_write |-> $past(ph_read));

    p_window_no_ram_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o != B_ADDR && ram_addr_o != X_ADDR && ram_addr_o != SP_ADDR));

    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ram_addr_o));

endmodule

bind ptr_mem_unit ptr_mem_unit_chk #(
    .W       (W),
    .B_ADDR  (B_ADDR),
    .X_ADDR  (X_ADDR),
    .SP_ADDR (SP_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .b_o        (b_o),
    .x_o        (x_o),
    .sp_o       (sp_o),
    .ph_read    (ph_read),
    .ph_write   (ph_write)
);

// File: tb/ptr_mem_unit_test.sv
module ptr_mem_unit_test;

    localparam logic [7:0] BA = 8'hFE;
    localparam logic [7:0] XA = 8'hFC;
    localparam logic [7:0] SA = 8'hFD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] op_i = '0, mode_i = '0, adj_i = '0;
    logic [7:0] dir_addr_i = '0, imm_i = '0, acc_i = '0;
    logic [7:0] ram_rdata_i, ram_addr_o, ram_wdata_o, acc_o, b_o, x_o, sp_o;
    logic       ram_we_o, done_o, busy_o;

    logic [7:0] ram [256];
    logic [7:0] mm  [256];
    logic [7:0] mb = '0, mx = '0, msp = '0, macc = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ptr_mem_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
        .adj_i(adj_i), .dir_addr_i(dir_addr_i), .imm_i(imm_i), .acc_i(acc_i),
        .ram_rdata_i(ram_rdata_i), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
        .ram_we_o(ram_we_o), .acc_o(acc_o), .done_o(done_o), .busy_o(busy_o),
        .b_o(b_o), .x_o(x_o), .sp_o(sp_o)
    );

    assign ram_rdata_i = ram[ram_addr_o];
    always @(posedge clk) if (ram_we_o) ram[ram_addr_o] <= ram_wdata_o;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic is_win(input logic [7:0] a);
        return a == BA || a == XA || a == SA;
    endfunction

    function automatic logic [7:0] win_rd(input logic [7:0] a);
        if (a == BA) return mb;
        if (a == XA) return mx;
        return msp;
    endfunction

    function automatic logic [7:0] calc_ea(input logic [1:0] md, input logic [7:0] da);
        if (md == 2'd1) return mb;
        if (md == 2'd2) return mx;
        return da;
    endfunction

    // One transfer: model, drive, compare. tag names the requirement for acc/pointer checks.
    task automatic do_op(input logic [1:0] op, input logic [1:0] md, input logic [1:0] aj,
                         input logic [7:0] da, input logic [7:0] im, input logic [7:0] ac,
                         input string tag, input bit poke);
        logic [7:0] ea, rd, wv;
        logic       wr, skip, hit;
        ea   = calc_ea(md, da);
        hit  = is_win(ea);
        rd   = hit ? win_rd(ea) : mm[ea];
        skip = (op == 2'd2) && (md == 2'd2);
        wr   = (op == 2'd1) || (op == 2'd2 && !skip);
        wv   = (op == 2'd1) ? ac : im;
        macc = (op == 2'd2) ? ac : rd;
        if (!skip && (aj == 2'd1 || aj == 2'd2)) begin
            if (md == 2'd1) mb = (aj == 2'd1) ? mb + 8'd1 : mb - 8'd1;
            if (md == 2'd2) mx = (aj == 2'd1) ? mx + 8'd1 : mx - 8'd1;
        end
        if (wr) begin
            if (ea == BA)      mb  = wv;
            else if (ea == XA) mx  = wv;
            else if (ea == SA) msp = wv;
            else               mm[ea] = wv;
        end

        @(negedge clk);
        start_i = 1'b1; op_i = op; mode_i = md; adj_i = aj;
        dir_addr_i = da; imm_i = im; acc_i = ac;
        @(negedge clk);
        if (poke) begin
            start_i = 1'b1; op_i = 2'd2; mode_i = 2'd0; dir_addr_i = 8'h10;
            imm_i = 8'hA5; acc_i = 8'h5A; adj_i = 2'd1;
        end else begin
            start_i = 1'b0;
        end
        chk("R2 address", {24'd0, ram_addr_o}, {24'd0, ea});
        chk(op == 2'd1 ? "R5 no write in read phase" : "R6 access write enable",
            {31'd0, ram_we_o}, {31'd0, (op == 2'd2 && !skip && !hit)});
        if (op == 2'd1) begin
            @(negedge clk);
            chk("R5 swap write enable", {31'd0, ram_we_o}, {31'd0, !hit});
            chk("R5 swap write data", {24'd0, ram_wdata_o}, {24'd0, ac});
            chk("R5 swap address", {24'd0, ram_addr_o}, {24'd0, ea});
        end
        @(negedge clk);
        start_i = 1'b0;
        chk("R3 done pulse", {31'd0, done_o}, 32'd1);
        chk({tag, " acc"}, {24'd0, acc_o}, {24'd0, macc});
        chk({tag, " B"},   {24'd0, b_o},   {24'd0, mb});
        chk({tag, " X"},   {24'd0, x_o},   {24'd0, mx});
        chk({tag, " SP"},  {24'd0, sp_o},  {24'd0, msp});
        if (!hit) chk({tag, " ram byte"}, {24'd0, ram[ea]}, {24'd0, mm[ea]});
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'($urandom);
            mm[i]  = ram[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 B", {24'd0, b_o}, 32'd0);
        chk("R1 X", {24'd0, x_o}, 32'd0);
        chk("R1 SP", {24'd0, sp_o}, 32'd0);
        chk("R1 acc", {24'd0, acc_o}, 32'd0);
        chk("R1 busy/done/we", {29'd0, busy_o, done_o, ram_we_o}, 32'd0);

        // R7 direct stores into the window load registers; direct load reads them back
        do_op(2'd2, 2'd0, 2'd1, BA, 8'h30, 8'h11, "R7 store B", 0);
        do_op(2'd2, 2'd0, 2'd0, XA, 8'h80, 8'h12, "R7 store X", 0);
        do_op(2'd2, 2'd0, 2'd0, SA, 8'h6C, 8'h13, "R7 store SP", 0);
        do_op(2'd0, 2'd0, 2'd2, SA, 8'h00, 8'h00, "R7 load SP", 0);
        do_op(2'd0, 2'd0, 2'd0, 8'hF3, 8'h00, 8'h00, "R7 other window byte", 0);

        // R3 / R4 / R5 indirect loads and exchanges
        do_op(2'd0, 2'd1, 2'd1, 8'h00, 8'h00, 8'h00, "R4 load B inc", 0);
        do_op(2'd0, 2'd2, 2'd2, 8'h00, 8'h00, 8'h00, "R4 load X dec", 0);
        do_op(2'd1, 2'd2, 2'd0, 8'h00, 8'h00, 8'hC3, "R5 xchg X", 0);
        do_op(2'd3, 2'd3, 2'd1, 8'h44, 8'h00, 8'h00, "R3 op3 mode3 load", 0);

        // R6 store through X is ignored; through B writes
        do_op(2'd2, 2'd2, 2'd1, 8'h00, 8'hEE, 8'h21, "R6 store X ignored", 0);
        do_op(2'd2, 2'd1, 2'd2, 8'h00, 8'h9D, 8'h22, "R6 store B dec", 0);

        // R10 wrap both ways
        do_op(2'd2, 2'd0, 2'd0, BA, 8'hFF, 8'h00, "R10 set B", 0);
        do_op(2'd0, 2'd1, 2'd1, 8'h00, 8'h00, 8'h00, "R10 B wrap up", 0);
        do_op(2'd2, 2'd0, 2'd0, XA, 8'h00, 8'h00, "R10 set X", 0);
        do_op(2'd0, 2'd2, 2'd2, 8'h00, 8'h00, 8'h00, "R10 X wrap down", 0);

        // R8 write to own pointer beats post-adjust
        do_op(2'd2, 2'd0, 2'd0, BA, BA, 8'h00, "R8 set B", 0);
        do_op(2'd2, 2'd1, 2'd1, 8'h00, 8'h40, 8'h00, "R8 store [B] inc", 0);
        do_op(2'd2, 2'd0, 2'd0, BA, BA, 8'h00, "R8 set B again", 0);
        do_op(2'd1, 2'd1, 2'd2, 8'h00, 8'h00, 8'h77, "R8 xchg [B] dec", 0);
        do_op(2'd2, 2'd0, 2'd0, XA, XA, 8'h00, "R8 set X", 0);
        do_op(2'd2, 2'd2, 2'd1, 8'h00, 8'h55, 8'h00, "R8 X store skip", 0);
        do_op(2'd1, 2'd2, 2'd1, 8'h00, 8'h00, 8'h3B, "R8 xchg [X] inc", 0);

        // R9 start while busy is ignored
        do_op(2'd0, 2'd0, 2'd0, 8'h20, 8'h00, 8'h00, "R9 load with poke", 1);
        do_op(2'd1, 2'd0, 2'd0, 8'h21, 8'h00, 8'h99, "R9 xchg with poke", 1);
        chk("R9 poked byte untouched", {24'd0, ram[8'h10]}, {24'd0, mm[8'h10]});

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [1:0] rop, rmd, raj;
            logic [7:0] rda;
            rop = 2'($urandom_range(3, 0));
            rmd = 2'($urandom_range(3, 0));
            raj = 2'($urandom_range(3, 0));
            rda = ($urandom_range(3, 0) == 0) ? 8'($urandom_range(255, 240)) : 8'($urandom);
            do_op(rop, rmd, raj, rda, 8'($urandom), 8'($urandom),
                  rop == 2'd1 ? "R5 random" : (rop == 2'd2 ? "R6 random" : "R3 random"),
                  k % 7 == 0);
        end

        for (int i = 0; i < 256; i++) begin
            if (!is_win(8'(i)) && ram[i] !== mm[i]) begin
                chk("R6 final memory", {24'd0, ram[i]}, {24'd0, mm[i]});
            end
        end
        chk("R4 idle pointers final B", {24'd0, b_o}, {24'd0, mb});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule